// File: doc/BRIEF.md
# Endpoint Interrupt DMA Request Gate

This block sits between one endpoint's bank-ready logic and the DMA channel that empties or fills the endpoint's banks. It walks the banks in ping-pong order, raises a request for the current bank when that bank is ready, and keeps the word position inside the bank. The DMA engine moves one word for each beat it reports while the request is high. After the last word of a bank, the block reports completion, releases the bank back to the bank logic and moves on to the next bank.

A gate bit, set and cleared by separate one-cycle strobes, lets any pending endpoint interrupt flag hold DMA back. The per-source interrupt enables play no part in this. Each source carries a fixed tag. A flag tied to a newly arrived bank lets a transfer already under way on the current bank run to its end, but no further bank is started. A flag not tied to a new bank, such as a NAK-type event, drops the request on the next clock, even in the middle of a bank. The transfer then resumes from its saved word position once the flag is acknowledged or the gate is cleared. With the gate clear, the request follows bank readiness alone.

Top module: `ep_dma_gate`

## Requirements
- R1: `gate_on` is 0 after reset. A one-cycle `gate_set` makes it 1 from the next cycle and `gate_clr` makes it 0. When both strobes are high in the same cycle, clear wins.
- R2: While `gate_on` is 0, `dma_req` is the value of `bank_ready[dma_bank]` registered one cycle earlier, whatever `irq_flag` holds. The one exception is the cycle after a bank's last beat, when it is 0.
- R3: While `gate_on` is 1 and any bit of `irq_flag` is 1 (also when its `irq_en` bit is 0), no transfer is started on a bank that has not begun. The request for that bank comes one cycle after all flags are clear or the gate is cleared.
- R4: While `gate_on` is 1, a flag whose bit in `NEW_BANK_MASK` is 0 forces `dma_req` to 0 from the next cycle, even in the middle of a bank.
- R5: While `gate_on` is 1, a flag whose bit in `NEW_BANK_MASK` is 1 does not stop a bank that has already begun. That bank completes, and the next bank is not requested while the flag stays set.
- R6: A bank paused in the middle resumes at its saved `dma_offset` when the request returns. It does not restart at word 0.
- R7: A beat taken while `dma_req` is 1 advances `dma_offset` by one. The beat at offset `BANK_WORDS-1` gives a one-cycle `dma_done` and a one-cycle one-hot `bank_release` bit for the finished bank on the next cycle. In that same cycle `dma_offset` returns to 0 and `dma_bank` advances as 0,1,...,`NUM_BANKS-1`,0.
- R8: `ep_irq` is the OR over sources of `irq_flag & irq_en`, registered one cycle. `irq_en` has no effect on `dma_req`.
- R9: A beat while `dma_req` is 0 is ignored: `dma_offset`, `dma_bank` and `dma_done` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_set | input | 1 | One-cycle strobe that sets the gate bit |
| gate_clr | input | 1 | One-cycle strobe that clears the gate bit (wins over set) |
| irq_flag | input | NUM_IRQ | Pending endpoint interrupt flags |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| bank_ready | input | NUM_BANKS | Bank holds data ready for DMA |
| dma_beat | input | 1 | DMA engine moved one word (counted only while dma_req is 1) |
| dma_req | output | 1 | DMA request for the current bank |
| dma_bank | output | BANK_W | Index of the current bank |
| dma_offset | output | OFF_W | Word position inside the current bank |
| dma_done | output | 1 | One-cycle pulse after the last word of a bank |
| bank_release | output | NUM_BANKS | One-cycle one-hot release of the finished bank |
| gate_on | output | 1 | Current gate bit |
| ep_irq | output | 1 | Registered endpoint interrupt line |

## Verification
The bench builds the block with four interrupt sources, two banks of four words each, and a tag mask that marks sources 0 and 1 as new-bank sources and sources 2 and 3 as NAK-type. With banks this short, several bank completions and the wrap of the ping-pong pointer fit into a few dozen cycles. A new-bank flag can then be raised while a bank is under way, so that the run completes and the following ready bank is seen to wait. A NAK-type flag can be raised in the middle of a bank, so that the pause, the ignored beats and the resume at the saved word position are all observed.

// File: rtl/epg_pkg.sv
package epg_pkg;

  typedef struct packed {
    logic new_hit;    // a flag tagged as new-bank is pending
    logic other_hit;  // a flag not tied to a new bank is pending
    logic line;       // enabled interrupt present
  } epg_irq_sum_t;

endpackage

// File: rtl/epg_gate_bit.sv
module epg_gate_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic gate_o
);

  always_ff @(posedge clk) begin
    if (rst)        gate_o <= 1'b0;
    else if (clr_i) gate_o <= 1'b0;
    else if (set_i) gate_o <= 1'b1;
  end

endmodule

// File: rtl/epg_irq_sort.sv
module epg_irq_sort
  import epg_pkg::*;
#(
  parameter int          NUM_IRQ       = 8,
  parameter logic [NUM_IRQ-1:0] NEW_BANK_MASK = '0
) (
  input  logic [NUM_IRQ-1:0] flag_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output epg_irq_sum_t       sum_o
);

  logic [NUM_IRQ-1:0] new_vec;
  logic [NUM_IRQ-1:0] oth_vec;
  logic [NUM_IRQ-1:0] en_vec;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    if (NEW_BANK_MASK[i]) begin : g_new
      assign new_vec[i] = flag_i[i];
      assign oth_vec[i] = 1'b0;
    end else begin : g_oth
      assign new_vec[i] = 1'b0;
      assign oth_vec[i] = flag_i[i];
    end
    assign en_vec[i] = flag_i[i] & en_i[i];
  end

  always_comb begin
    sum_o.new_hit   = |new_vec;
    sum_o.other_hit = |oth_vec;
    sum_o.line      = |en_vec;
  end

endmodule

// File: rtl/epg_bank_walker.sv
module epg_bank_walker #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WORDS = 512,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFF_W  = $clog2(BANK_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_q_i,   // request currently presented
  input  logic                 start_i,   // request asserted for next cycle
  input  logic                 beat_i,
  output logic                 last_o,    // final beat of bank taken now
  output logic                 active_o,  // current bank has begun
  output logic [BANK_W-1:0]    bank_o,
  output logic [OFF_W-1:0]     off_o,
  output logic                 done_o,
  output logic [NUM_BANKS-1:0] release_o
);

  localparam logic [OFF_W-1:0]  LAST_OFF = OFF_W'(BANK_WORDS - 1);
  localparam logic [BANK_W-1:0] LAST_BNK = BANK_W'(NUM_BANKS - 1);

  logic take;
  assign take   = beat_i & req_q_i;
  assign last_o = take & (off_o == LAST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_o    <= '0;
      off_o     <= '0;
      active_o  <= 1'b0;
      done_o    <= 1'b0;
      release_o <= '0;
    end else begin
      done_o    <= last_o;
      release_o <= '0;
      if (last_o) begin
        off_o           <= '0;
        active_o        <= 1'b0;
        release_o[bank_o] <= 1'b1;
        bank_o          <= (bank_o == LAST_BNK) ? '0 : bank_o + 1'b1;
      end else begin
        if (take)    off_o    <= off_o + 1'b1;
        if (start_i) active_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate
  import epg_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WORDS = 512,
  parameter logic [NUM_IRQ-1:0] NEW_BANK_MASK = 8'h0F,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFF_W  = $clog2(BANK_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gate_set,
  input  logic                 gate_clr,
  input  logic [NUM_IRQ-1:0]   irq_flag,
  input  logic [NUM_IRQ-1:0]   irq_en,
  input  logic [NUM_BANKS-1:0] bank_ready,
  input  logic                 dma_beat,
  output logic                 dma_req,
  output logic [BANK_W-1:0]    dma_bank,
  output logic [OFF_W-1:0]     dma_offset,
  output logic                 dma_done,
  output logic [NUM_BANKS-1:0] bank_release,
  output logic                 gate_on,
  output logic                 ep_irq
);

  epg_irq_sum_t sum;
  logic         last, active, req_nxt, cur_ready;

  epg_gate_bit u_gate (
    .clk(clk), .rst(rst), .set_i(gate_set), .clr_i(gate_clr), .gate_o(gate_on)
  );

  epg_irq_sort #(.NUM_IRQ(NUM_IRQ), .NEW_BANK_MASK(NEW_BANK_MASK)) u_sort (
    .flag_i(irq_flag), .en_i(irq_en), .sum_o(sum)
  );

  epg_bank_walker #(.NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS)) u_walk (
    .clk(clk), .rst(rst), .req_q_i(dma_req), .start_i(req_nxt),
    .beat_i(dma_beat), .last_o(last), .active_o(active),
    .bank_o(dma_bank), .off_o(dma_offset), .done_o(dma_done),
    .release_o(bank_release)
  );

  assign cur_ready = bank_ready[dma_bank];

  // Begun bank: only non-new-bank flags pause it. Fresh bank: any flag holds it.
  always_comb begin
    if (last)        req_nxt = 1'b0;
    else if (active) req_nxt = cur_ready & ~(gate_on & sum.other_hit);
    else             req_nxt = cur_ready & ~(gate_on & (sum.other_hit | sum.new_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req <= 1'b0;
      ep_irq  <= 1'b0;
    end else begin
      dma_req <= req_nxt;
      ep_irq  <= sum.line;
    end
  end

endmodule

// File: rtl/ep_dma_gate_chk.sv
module ep_dma_gate_chk #(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 1,
  parameter int OFF_W      = 9,
  parameter logic [NUM_IRQ-1:0] NEW_BANK_MASK = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gate_set,
  input logic                 gate_clr,
  input logic [NUM_IRQ-1:0]   irq_flag,
  input logic [NUM_IRQ-1:0]   irq_en,
  input logic                 dma_req,
  input logic [BANK_W-1:0]    dma_bank,
  input logic [OFF_W-1:0]     dma_offset,
  input logic                 dma_done,
  input logic [NUM_BANKS-1:0] bank_release,
  input logic                 gate_on,
  input logic                 ep_irq
);

  a_r1_clr_wins: assert property (@(posedge clk) disable iff (rst)
    gate_clr |=> !gate_on);

  a_r1_set: assert property (@(posedge clk) disable iff (rst)
    (gate_set && !gate_clr) |=> gate_on);

  a_r4_nak_drops: assert property (@(posedge clk) disable iff (rst)
    (gate_on && !gate_clr && |(irq_flag & ~NEW_BANK_MASK)) |=> !dma_req);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !dma_req |=> ($stable(dma_offset) && $stable(dma_bank) && !dma_done));

  a_r7_release_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_release) && (dma_done == (bank_release != '0)));

  a_r7_done_rewinds: assert property (@(posedge clk) disable iff (rst)
    dma_done |-> (dma_offset == '0 && !dma_req));

  a_r8_irq_line: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ep_irq == $past(|(irq_flag & irq_en))));

endmodule

bind ep_dma_gate ep_dma_gate_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .OFF_W(OFF_W),
  .NEW_BANK_MASK(NEW_BANK_MASK)
) u_chk (.*);

// File: tb/ep_dma_gate_tb.sv
module ep_dma_gate_tb;
  localparam int NI = 4, NB = 2, BW = 4;
  localparam logic [NI-1:0] NMASK = 4'b0011;

  logic clk = 0, rst = 1, gate_set = 0, gate_clr = 0, dma_beat = 0;
  logic [NI-1:0] irq_flag = '0, irq_en = '0;
  logic [NB-1:0] bank_ready = '0;
  logic dma_req, dma_done, gate_on, ep_irq;
  logic [0:0] dma_bank;
  logic [1:0] dma_offset;
  logic [NB-1:0] bank_release;

  int checks = 0, errors = 0, cyc = 0;
  int m_gate, m_cur, m_off, m_act, m_req, m_done, m_rel, m_irq;

  always #2.5 clk = ~clk;

  ep_dma_gate #(.NUM_IRQ(NI), .NUM_BANKS(NB), .BANK_WORDS(BW), .NEW_BANK_MASK(NMASK)) u_dut (
    .clk, .rst, .gate_set, .gate_clr, .irq_flag, .irq_en, .bank_ready, .dma_beat,
    .dma_req, .dma_bank, .dma_offset, .dma_done, .bank_release, .gate_on, .ep_irq);

  // behavioural reference
  always @(posedge clk) begin
    bit pn, po, last, rq;
    cyc++;
    if (rst) begin
      m_gate = 0; m_cur = 0; m_off = 0; m_act = 0; m_req = 0;
      m_done = 0; m_rel = 0; m_irq = 0;
    end else begin
      pn = (irq_flag & NMASK) != 0;
      po = (irq_flag & ~NMASK) != 0;
      last = dma_beat && m_req && (m_off == BW - 1);
      if (last) rq = 0;
      else if (m_act) rq = bank_ready[m_cur] && !(m_gate && po);
      else rq = bank_ready[m_cur] && !(m_gate && (pn || po));
      m_rel = last ? (1 << m_cur) : 0;
      m_done = last;
      if (last) begin m_off = 0; m_act = 0; m_cur = (m_cur + 1) % NB; end
      else begin
        if (dma_beat && m_req) m_off++;
        if (rq) m_act = 1;
      end
      m_req = rq;
      m_irq = (irq_flag & irq_en) != 0;
      m_gate = gate_clr ? 0 : gate_set ? 1 : m_gate;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    chk("R1 gate_on", gate_on, m_gate);
    chk("R2 dma_req", dma_req, m_req);
    chk("R6 dma_offset", dma_offset, m_off);
    chk("R7 dma_bank", dma_bank, m_cur);
    chk("R7 dma_done", dma_done, m_done);
    chk("R7 bank_release", bank_release, m_rel);
    chk("R8 ep_irq", ep_irq, m_irq);
    for (int b = 0; b < NB; b++) if (bank_release[b]) bank_ready[b] = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int saved;
    run(3);
    chk("R1 reset gate", gate_on, 0);
    chk("R1 reset req", dma_req, 0);
    rst = 0;
    // R2: gate clear, flags ignored
    irq_flag = 4'b1111; bank_ready = 2'b01; dma_beat = 1;
    run(8);
    chk("R7 pointer to bank1", dma_bank, 1);
    bank_ready[1] = 1;
    run(8);
    chk("R7 pointer wraps to bank0", dma_bank, 0);
    irq_flag = 0;
    // R3: gate on, masked new-bank flag holds a fresh bank
    gate_set = 1; tick(); gate_set = 0;
    chk("R1 gate set", gate_on, 1);
    irq_flag = 4'b0001; irq_en = 0; bank_ready[0] = 1;
    run(4);
    chk("R3 no start", dma_req, 0);
    irq_flag = 0;
    run(2);
    chk("R3 start after ack", dma_req, 1);
    // R4/R9/R6: NAK-type flag mid-bank
    irq_flag = 4'b0100;
    tick();
    chk("R4 drop next cycle", dma_req, 0);
    saved = dma_offset;
    run(3);
    chk("R9 offset held", dma_offset, saved);
    irq_flag = 0;
    run(2);
    chk("R6 resume no restart", int'(dma_offset) >= saved, 1);
    run(6);
    // R5: new-bank flag during a begun bank
    bank_ready = 2'b11;
    run(2);
    irq_flag = 4'b0010;
    run(8);
    chk("R5 next bank waits", dma_req, 0);
    chk("R5 finished bank1", dma_bank, 0);
    gate_clr = 1; tick(); gate_clr = 0;
    tick();
    chk("R2 gate clear resumes", dma_req, 1);
    irq_flag = 0;
    run(6);
    // R1: clear wins
    gate_set = 1; gate_clr = 1; tick(); gate_set = 0; gate_clr = 0;
    chk("R1 clear wins", gate_on, 0);
    // R8
    irq_flag = 4'b1000; irq_en = 4'b1000; tick();
    chk("R8 line high", ep_irq, 1);
    irq_en = 0; tick();
    chk("R8 line low", ep_irq, 0);
    irq_flag = 0; run(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule